// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is the controller side of the two-wire PHY management bus. A host asks for one register access by pulsing a start request together with a direction flag, a PHY address, a register address and, when writing, a data word. The block then generates the management clock itself and serialises the whole frame: a run of idle-high bits, the start and opcode bits, both addresses, the turnaround and the data. When the access ends it reports completion with a one-cycle pulse, an error flag and, for a good read, the returned register value.

The bidirectional data line is handled through three pins: a value to drive, a drive enable, and the sampled line level. The sampled level passes through a two-flop synchroniser. Because of that, the master takes each read bit at the last system clock of the clock-high phase and not at the rising edge. If the PHY does not pull the turnaround bit low on a read, the master sends a run of recovery clocks with the line released, reports an error and returns no data.

The management clock half period is a parameter counted in system clocks. Every bus bit takes one "slot" of two half periods: the clock is low for the first half and high for the second. Outgoing bits change only when the clock falls.

Top module: `mdio_master`

## Requirements
- R1: After reset, mdc_o, mdio_oe_o, busy_o, done_o and err_o are all 0 and rdata_o is 0.
- R2: Every access starts with PRE_LEN (32) slots in which mdio_oe_o=1 and mdio_o=1.
- R3: Next come 14 driven header bits in this order: start 0,1; opcode 1,0 for a read or 0,1 for a write; the 5-bit PHY address MSB first; the 5-bit register address MSB first.
- R4: Each slot is HALF_CYC cycles with mdc_o low, then HALF_CYC cycles with mdc_o high. The first slot begins in the cycle after acceptance. mdio_o and mdio_oe_o never change while mdc_o is high, and they never change in the cycle mdc_o rises.
- R5: A write drives the turnaround 1,0 and then the 16 data bits MSB first. The line is then released for one more slot, so a write takes 65 slots.
- R6: A read releases the line from the turnaround slot onward. The PHY must drive 0 in that slot. The master then captures 16 data bits MSB first, each from the line level during the high phase of its slot, and adds 2 released trailing slots. A good read takes 65 slots, and rdata_o holds the captured word when done_o pulses.
- R7: If the turnaround is sampled as 1, the master sends RECOV_LEN (32) further released slots, skips data capture, and reports err_o=1 with rdata_o=0. The access then takes 79 slots.
- R8: start_i is accepted only while busy_o is 0. busy_o is high from the cycle after acceptance until the cycle in which done_o pulses for exactly one cycle. A request raised while busy_o is high changes nothing on the bus.
- R9: err_o changes only when done_o pulses or when a new access is accepted. A write or a good read reports err_o=0, and rdata_o=0 after a write.
- R10: Whenever busy_o is 0, mdc_o is low and mdio_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one access (taken when idle) |
| read_i | input | 1 | 1 = read, 0 = write |
| phy_addr_i | input | 5 | PHY address |
| reg_addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Data to write |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Turnaround failure of the last access |
| rdata_o | output | 16 | Data of the last good read |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Value to drive on the data line |
| mdio_oe_o | output | 1 | Drive enable of the data line |
| mdio_i | input | 1 | Sampled data line level |

## Verification
Time is counted from t=0, the first cycle after the accepting clock edge. For that cycle the bench predicts mdc_o as high exactly when (t mod 2·HALF_CYC) ≥ HALF_CYC, and it predicts the drive enable and value from slot index t/(2·HALF_CYC). done_o, err_o and rdata_o are due at t = slots·2·HALF_CYC, which is 65 or 79 slots. All outputs are compared at the falling system clock edge of every cycle, so each registered change is seen one cycle after the edge that makes it. The behavioural PHY applies each reply bit from the first cycle of its slot, which gives the two-flop synchroniser time to deliver it before the sample point at the end of the high phase.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SHIFT,
        ST_TA,
        ST_RDATA,
        ST_TAIL
    } mdio_state_e;

    localparam logic [1:0] FRAME_START = 2'b01;
    localparam logic [1:0] OP_READ     = 2'b10;
    localparam logic [1:0] OP_WRITE    = 2'b01;
    localparam logic [1:0] TA_WRITE    = 2'b10;

endpackage

// File: rtl/mdio_halfper.sv
module mdio_halfper #(
    parameter int HALF_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run_i)             cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = '0;
        else                    cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = run_i && (cnt_q == LAST);

    // the counter never passes the end of the half period (R4)
    assert_halfper_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/mdio_sync2.sv
module mdio_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [1:0] ff_d, ff_q;

    always_comb ff_d = {ff_q[0], d_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= 2'b11;
        else        ff_q <= ff_d;
    end

    assign q_o = ff_q[1];
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_CYC  = 10,
    parameter int PRE_LEN   = 32,
    parameter int RECOV_LEN = 32,
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              read_i,
    input  logic [ADDR_W-1:0] phy_addr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              mdc_o,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    input  logic              mdio_i
);
    localparam int HDR_W   = 4 + 2 * ADDR_W;
    localparam int TXW     = HDR_W + 2 + DATA_W;
    localparam int CNT_W   = $clog2(PRE_LEN + RECOV_LEN + TXW + 1);
    localparam int WR_TAIL = 1;
    localparam int RD_TAIL = 2;

    typedef struct packed {
        mdio_state_e       st;
        logic [CNT_W-1:0]  cnt;
        logic [TXW-1:0]    tx;
        logic [DATA_W-1:0] rx;
        logic              rd;
        logic              ta_bad;
        logic              busy;
        logic              done;
        logic              err;
        logic [DATA_W-1:0] rdata;
        logic              mdc;
        logic              mo;
        logic              moe;
    } mdio_regs_t;

    mdio_regs_t r_d, r_q;
    logic       tick;
    logic       line_s;
    logic       slot_end;
    logic       rise;

    mdio_halfper #(.HALF_CYC(HALF_CYC)) u_halfper (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (r_q.busy),
        .tick_o (tick)
    );

    mdio_sync2 u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (mdio_i),
        .q_o   (line_s)
    );

    assign slot_end = tick && r_q.mdc;
    assign rise     = tick && !r_q.mdc;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (r_q.st == ST_IDLE) begin
            if (start_i) begin
                r_d.st     = ST_PRE;
                r_d.cnt    = CNT_W'(PRE_LEN - 1);
                r_d.tx     = read_i ? {FRAME_START, OP_READ, phy_addr_i, reg_addr_i,
                                       {(2 + DATA_W){1'b0}}}
                                    : {FRAME_START, OP_WRITE, phy_addr_i, reg_addr_i,
                                       TA_WRITE, wdata_i};
                r_d.rd     = read_i;
                r_d.rx     = '0;
                r_d.ta_bad = 1'b0;
                r_d.busy   = 1'b1;
                r_d.err    = 1'b0;
                r_d.mo     = 1'b1;
                r_d.moe    = 1'b1;
            end
        end else begin
            if (rise) r_d.mdc = 1'b1;
            if (slot_end) begin
                r_d.mdc = 1'b0;
                unique case (r_q.st)
                    ST_PRE: begin
                        if (r_q.cnt == '0) begin
                            r_d.st  = ST_SHIFT;
                            r_d.cnt = r_q.rd ? CNT_W'(HDR_W - 1) : CNT_W'(TXW - 1);
                            r_d.mo  = r_q.tx[TXW-1];
                            r_d.tx  = r_q.tx << 1;
                        end else begin
                            r_d.cnt = r_q.cnt - CNT_W'(1);
                        end
                    end
                    ST_SHIFT: begin
                        if (r_q.cnt == '0) begin
                            r_d.moe = 1'b0;
                            r_d.mo  = 1'b0;
                            if (r_q.rd) begin
                                r_d.st = ST_TA;
                            end else begin
                                r_d.st  = ST_TAIL;
                                r_d.cnt = CNT_W'(WR_TAIL - 1);
                            end
                        end else begin
                            r_d.cnt = r_q.cnt - CNT_W'(1);
                            r_d.mo  = r_q.tx[TXW-1];
                            r_d.tx  = r_q.tx << 1;
                        end
                    end
                    ST_TA: begin
                        if (line_s) begin
                            r_d.ta_bad = 1'b1;
                            r_d.st     = ST_TAIL;
                            r_d.cnt    = CNT_W'(RECOV_LEN - 1);
                        end else begin
                            r_d.st  = ST_RDATA;
                            r_d.cnt = CNT_W'(DATA_W - 1);
                        end
                    end
                    ST_RDATA: begin
                        r_d.rx = {r_q.rx[DATA_W-2:0], line_s};
                        if (r_q.cnt == '0) begin
                            r_d.st  = ST_TAIL;
                            r_d.cnt = CNT_W'(RD_TAIL - 1);
                        end else begin
                            r_d.cnt = r_q.cnt - CNT_W'(1);
                        end
                    end
                    ST_TAIL: begin
                        if (r_q.cnt == '0) begin
                            r_d.st    = ST_IDLE;
                            r_d.busy  = 1'b0;
                            r_d.done  = 1'b1;
                            r_d.err   = r_q.ta_bad;
                            r_d.rdata = (r_q.rd && !r_q.ta_bad) ? r_q.rx : '0;
                        end else begin
                            r_d.cnt = r_q.cnt - CNT_W'(1);
                        end
                    end
                    default: r_d.st = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
        end else begin
            r_q       <= r_d;
        end
    end

    assign busy_o    = r_q.busy;
    assign done_o    = r_q.done;
    assign err_o     = r_q.err;
    assign rdata_o   = r_q.rdata;
    assign mdc_o     = r_q.mdc;
    assign mdio_o    = r_q.mo;
    assign mdio_oe_o = r_q.moe;

    // bus quiet while idle
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.busy |-> (!r_q.mdc && !r_q.moe));

    // outgoing bits held through the high phase
    assert_bit_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.mdc |-> ($stable(r_q.mo) && $stable(r_q.moe)));

    // the clock only moves on a divider tick
    assert_mdc_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mdc != $past(r_q.mdc)) |-> $past(tick));

    // done is a single pulse that closes a busy window
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |=> !r_q.done);

    assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> (!r_q.busy && $past(r_q.busy)));

    // error flag moves only at completion or acceptance
    assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(r_q.err) |-> (r_q.done || $rose(r_q.busy)));

    // line released while read data is coming in
    assert_read_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RDATA || r_q.st == ST_TA) |-> !r_q.moe);

endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
    localparam int H  = 4;
    localparam int SL = 2 * H;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        read_i = 1'b0;
    logic [4:0]  phy_addr_i = '0;
    logic [4:0]  reg_addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic        busy_o, done_o, err_o, mdc_o, mdio_o, mdio_oe_o;
    logic [15:0] rdata_o;
    logic        phy_bit = 1'b1;
    logic        mdio_i;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    assign mdio_i = mdio_oe_o ? mdio_o : phy_bit;

    mdio_master #(.HALF_CYC(H)) u_mdio_master (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .read_i(read_i),
        .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wdata_i(wdata_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .rdata_o(rdata_o),
        .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_oe(input bit rd, input int slot);
        if (slot < 46) return 1'b1;
        if (!rd && slot < 64) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit exp_o(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                                 input logic [15:0] wd, input int slot);
        logic [31:0] fr;
        fr = {2'b01, (rd ? 2'b10 : 2'b01), pa, ra, (rd ? 18'h0 : {2'b10, wd})};
        if (slot < 32) return 1'b1;
        return fr[31 - (slot - 32)];
    endfunction

    // behavioural PHY reply for a slot
    function automatic bit phy_val(input bit rd, input bit fail, input logic [15:0] pd,
                                   input int slot);
        if (!rd) return 1'b1;
        if (slot == 46) return fail;
        if (!fail && slot >= 47 && slot <= 62) return pd[15 - (slot - 47)];
        return 1'b1;
    endfunction

    task automatic run_op(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] wd, input logic [15:0] pd, input bit fail,
                          input bit poke);
        int nslots;
        int total;
        nslots = (rd && fail) ? 79 : 65;
        total  = nslots * SL;
        @(negedge clk);
        read_i = rd; phy_addr_i = pa; reg_addr_i = ra; wdata_i = wd; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int t = 0; t <= total; t++) begin
            int slot;
            slot = t / SL;
            if (t < total) begin
                chk(busy_o == 1'b1, "R8 busy", busy_o, 1);
                chk(done_o == 1'b0, "R8 done early", done_o, 0);
                chk(mdc_o == ((t % SL) >= H), "R4 mdc phase", mdc_o, ((t % SL) >= H));
                chk(mdio_oe_o == exp_oe(rd, slot), "R2 R3 R5 R6 R7 drive enable",
                    mdio_oe_o, exp_oe(rd, slot));
                if (exp_oe(rd, slot))
                    chk(mdio_o == exp_o(rd, pa, ra, wd, slot), "R2 R3 R5 bit value",
                        mdio_o, exp_o(rd, pa, ra, wd, slot));
                phy_bit = phy_val(rd, fail, pd, slot);
            end else begin
                phy_bit = 1'b1;
                chk(busy_o == 1'b0, "R8 busy end", busy_o, 0);
                chk(done_o == 1'b1, "R8 done due", done_o, 1);
                chk(err_o == (rd && fail), "R7 R9 error flag", err_o, (rd && fail));
                chk(rdata_o == ((rd && !fail) ? pd : 16'h0), "R6 R7 R9 read data",
                    rdata_o, ((rd && !fail) ? pd : 16'h0));
                chk(mdc_o == 1'b0 && mdio_oe_o == 1'b0, "R10 idle bus",
                    {mdc_o, mdio_oe_o}, 0);
            end
            if (poke && t == 5) begin
                start_i = 1'b1; read_i = !rd; phy_addr_i = ~pa; reg_addr_i = ~ra;
            end
            if (poke && t == 9) start_i = 1'b0;
            @(negedge clk);
        end
        chk(done_o == 1'b0, "R8 done single", done_o, 0);
        chk(busy_o == 1'b0, "R8 no stray accept", busy_o, 0);
        chk(err_o == (rd && fail), "R9 err held", err_o, (rd && fail));
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(mdc_o == 0 && mdio_oe_o == 0, "R1 reset bus", {mdc_o, mdio_oe_o}, 0);
        chk(busy_o == 0 && done_o == 0 && err_o == 0, "R1 reset flags",
            {busy_o, done_o, err_o}, 0);
        chk(rdata_o == 16'h0, "R1 reset data", rdata_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy_o == 0 && mdc_o == 0, "R10 idle after reset", {busy_o, mdc_o}, 0);
        // write with mixed bits
        run_op(1'b0, 5'h01, 5'h1F, 16'hA5C3, 16'h0, 1'b0, 1'b0);
        // good read
        run_op(1'b1, 5'h10, 5'h0A, 16'h0, 16'hBEEF, 1'b0, 1'b0);
        // read with turnaround failure (R7)
        run_op(1'b1, 5'h03, 5'h11, 16'h0, 16'h1234, 1'b1, 1'b0);
        // write after failure clears error (R9), request while busy ignored (R8)
        run_op(1'b0, 5'h1E, 5'h00, 16'hFFFF, 16'h0, 1'b0, 1'b1);
        // read with edge patterns and all-ones addresses
        run_op(1'b1, 5'h1F, 5'h1F, 16'h0, 16'h8001, 1'b0, 1'b1);
        run_op(1'b1, 5'h00, 5'h00, 16'h0, 16'h0000, 1'b0, 1'b0);
        run_op(1'b0, 5'h00, 5'h15, 16'h0001, 16'h0, 1'b0, 1'b0);
        chk(rdata_o == 16'h0, "R9 write clears data", rdata_o, 0);
        finish_up();
    end
endmodule